// File: doc/BRIEF.md
# Indirect Management Register Access Target

This block is the register-level back end of a management-bus target. Each request from a slave port that has already deserialised the bus traffic carries a bus address, a register offset, a direction and write data. The block answers with an acknowledge and read data one cycle later. Behind it sits a large internal register space, organised as devices and registers, reached through a simple single-cycle register-file port. The register file reads combinationally and is written on the clock edge.

A strap input selects the addressing scheme. With a strap of zero the target answers every bus address. The bus address becomes the internal device address, and the register offset passes straight through. With a nonzero strap the target answers only that address and exposes just two registers: a command register at offset 0 and a data register at offset 1. Software writes the data register first for a write. It then issues a command with the busy bit set and polls the command register until busy clears. For a read, the data register holds the result once busy has cleared.

Each command keeps busy set for a fixed, parameterised number of cycles. The block performs the internal access in the last of those cycles and then clears busy by itself.

Top module: `smi_indirect_tgt`

## Requirements
- R1: With a nonzero strap, a request to any bus address other than the strap gets no acknowledge (bus_ack_o stays 0) and changes neither the command register, the data register nor any internal register.
- R2: A read of offset 0 returns the last accepted command in bits 14:0 and the live busy state in bit 15. A command written with bit 15 clear is stored but starts nothing.
- R3: A command write with bit 15 set, accepted while idle, sets busy. Busy then reads as 1 for exactly BUSY_CYCLES consecutive polls and then clears by itself.
- R4: A command write arriving while busy is set is ignored. The stored command and the operation in progress are unaffected.
- R5: A command with bit 12 set and bits 11:10 equal to 1 writes the data register to the internal register. The device comes from command bits 9:5 and the register from bits 4:0. This is one register-file write per command.
- R6: A command with bit 12 set and bits 11:10 equal to 2 reads the addressed internal register. The value is in the data register when busy clears.
- R7: A command whose bit 12 is clear, or whose opcode is neither 1 nor 2, still runs busy to completion but makes no register-file access. The data register keeps its value.
- R8: With a strap of zero, every bus address is acknowledged. The bus address is the internal device address and the bus register offset is the internal register. Offsets 0 and 1 are plain internal registers, not the command and data registers.
- R9: After reset, bus_ack_o and bus_rdata_o are 0, no register-file request is made, and the command and data registers read as 0.
- R10: bus_ack_o and bus_rdata_o are valid on the cycle after the request and return to 0 on the next idle cycle. Write requests return read data 0.
- R11: With a nonzero strap, offsets other than 0 and 1 at the strap address are acknowledged, read as 0, and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_addr_i | input | 5 | Strapped chip address; 0 selects direct mode |
| bus_req_i | input | 1 | One-cycle request from the slave port |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_phy_i | input | 5 | Bus address of the request |
| bus_reg_i | input | 5 | Register offset of the request |
| bus_wdata_i | input | 16 | Write data |
| bus_ack_o | output | 1 | Request was addressed to this target (one cycle later) |
| bus_rdata_o | output | 16 | Read data (one cycle later) |
| rf_req_o | output | 1 | Internal register-file access strobe |
| rf_we_o | output | 1 | Internal access is a write |
| rf_dev_o | output | 5 | Internal device address |
| rf_reg_o | output | 5 | Internal register offset |
| rf_wdata_o | output | 16 | Internal write data |
| rf_rdata_i | input | 16 | Internal read data (combinational) |

## Verification
The bench counts back-to-back polls of busy after a command. An off-by-one timer would show BUSY_CYCLES plus or minus one. It also issues a second command in the middle of a read. A design that accepts it would overwrite the stored command and corrupt a register it was never meant to touch.

Commands with clause bit 12 clear or with opcode 3 are checked against a count of register-file strobes and the untouched data register. This catches a decoder that treats any opcode as a write. Foreign addresses under a nonzero strap must leave the data register intact. Direct mode must read offset 1 as an ordinary internal register, which exposes a design that still applies indirection when the strap is zero.

// File: rtl/smi_ind_pkg.sv
package smi_ind_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 16;
  // command field positions
  localparam int unsigned BUSY_BIT = 15;
  localparam int unsigned C22_BIT  = 12;
  localparam int unsigned OP_LSB   = 10;
  localparam int unsigned DEV_LSB  = 5;
  localparam int unsigned REG_LSB  = 0;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_RSV  = 2'd3
  } smi_op_e;
endpackage

// File: rtl/smi_busy_timer.sv
module smi_busy_timer #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES);
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/smi_cmd_decode.sv
module smi_cmd_decode
  import smi_ind_pkg::*;
(
  input  logic       c22_i,
  input  logic [1:0] op_i,
  output logic       is_wr_o,
  output logic       is_rd_o
);
  smi_op_e op;
  assign op = smi_op_e'(op_i);

  always_comb begin
    is_wr_o = 1'b0;
    is_rd_o = 1'b0;
    if (c22_i) begin
      unique case (op)
        OP_WR:   is_wr_o = 1'b1;
        OP_RD:   is_rd_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smi_indirect_tgt.sv
module smi_indirect_tgt
  import smi_ind_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] strap_addr_i,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_phy_i,
  input  logic [AW-1:0] bus_reg_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic          bus_ack_o,
  output logic [DW-1:0] bus_rdata_o,
  output logic          rf_req_o,
  output logic          rf_we_o,
  output logic [AW-1:0] rf_dev_o,
  output logic [AW-1:0] rf_reg_o,
  output logic [DW-1:0] rf_wdata_o,
  input  logic [DW-1:0] rf_rdata_i
);
  localparam logic [AW-1:0] CMD_OFS  = AW'(0);
  localparam logic [AW-1:0] DATA_OFS = AW'(1);

  logic          direct_mode, hit, sel_cmd, sel_data, cmd_wr, start;
  logic          busy, done, dec_wr, dec_rd, eng_fire;
  logic [DW-2:0] cmd_q;
  logic [DW-1:0] data_q, rd_mux, rdata_q;
  logic          ack_q;

  assign direct_mode = (strap_addr_i == '0);
  assign hit      = bus_req_i && (direct_mode || (bus_phy_i == strap_addr_i));
  assign sel_cmd  = hit && !direct_mode && (bus_reg_i == CMD_OFS);
  assign sel_data = hit && !direct_mode && (bus_reg_i == DATA_OFS);
  assign cmd_wr   = sel_cmd && bus_we_i && !busy;
  assign start    = cmd_wr && bus_wdata_i[BUSY_BIT];

  smi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  smi_cmd_decode u_dec (
    .c22_i   (cmd_q[C22_BIT]),
    .op_i    (cmd_q[OP_LSB +: 2]),
    .is_wr_o (dec_wr),
    .is_rd_o (dec_rd)
  );

  assign eng_fire = done && (dec_wr || dec_rd);

  // register-file port: bus pass-through in direct mode, engine otherwise
  always_comb begin
    if (direct_mode) begin
      rf_req_o   = hit;
      rf_we_o    = bus_we_i;
      rf_dev_o   = bus_phy_i;
      rf_reg_o   = bus_reg_i;
      rf_wdata_o = bus_wdata_i;
    end else begin
      rf_req_o   = eng_fire;
      rf_we_o    = dec_wr;
      rf_dev_o   = cmd_q[DEV_LSB +: AW];
      rf_reg_o   = cmd_q[REG_LSB +: AW];
      rf_wdata_o = data_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit && !bus_we_i) begin
      if (direct_mode)   rd_mux = rf_rdata_i;
      else if (sel_cmd)  rd_mux = {busy, cmd_q};
      else if (sel_data) rd_mux = data_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (cmd_wr) begin
      cmd_q <= bus_wdata_i[DW-2:0];
    end
  end

  // completion of an internal read wins over a same-cycle bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (eng_fire && dec_rd) begin
      data_q <= rf_rdata_i;
    end else if (sel_data && bus_we_i) begin
      data_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= hit;
      rdata_q <= rd_mux;
    end
  end

  assign bus_ack_o   = ack_q;
  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/smi_indirect_chk.sv
module smi_indirect_chk
  import smi_ind_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] strap_addr_i,
  input logic          bus_req_i,
  input logic          bus_we_i,
  input logic [AW-1:0] bus_phy_i,
  input logic [AW-1:0] bus_reg_i,
  input logic          start_bit_i,
  input logic          bus_ack_o,
  input logic          rf_req_o,
  input logic          busy_i,
  input logic          done_i
);
  logic indirect;
  assign indirect = (strap_addr_i != '0);

  AST_FOREIGN_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && indirect && (bus_phy_i != strap_addr_i) |=> !bus_ack_o); // R1
  AST_DIRECT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !indirect |=> bus_ack_o); // R8
  AST_ACK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |-> $past(bus_req_i)); // R10
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && bus_we_i && indirect && (bus_phy_i == strap_addr_i) &&
    (bus_reg_i == '0) && start_bit_i && !busy_i |=> busy_i); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |=> busy_i); // R3
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !busy_i); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    indirect && !busy_i |-> !rf_req_o); // R7
  AST_RF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    indirect && rf_req_o |=> !rf_req_o); // R5
endmodule

bind smi_indirect_tgt smi_indirect_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .strap_addr_i (strap_addr_i),
  .bus_req_i    (bus_req_i),
  .bus_we_i     (bus_we_i),
  .bus_phy_i    (bus_phy_i),
  .bus_reg_i    (bus_reg_i),
  .start_bit_i  (bus_wdata_i[15]),
  .bus_ack_o    (bus_ack_o),
  .rf_req_o     (rf_req_o),
  .busy_i       (busy),
  .done_i       (done)
);

// File: tb/smi_indirect_tgt_tb_top.sv
`timescale 1ns/1ps
module smi_indirect_tgt_tb_top;
  localparam int unsigned LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap = 5'h12;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_phy = '0, bus_reg = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_ack;
  logic [15:0] bus_rdata;
  logic        rf_req, rf_we;
  logic [4:0]  rf_dev, rf_reg;
  logic [15:0] rf_wdata, rf_rdata;

  int n_chk = 0, n_err = 0;
  int rf_cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  smi_indirect_tgt #(.BUSY_CYCLES(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strap_addr_i(strap),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_phy_i(bus_phy),
    .bus_reg_i(bus_reg), .bus_wdata_i(bus_wdata),
    .bus_ack_o(bus_ack), .bus_rdata_o(bus_rdata),
    .rf_req_o(rf_req), .rf_we_o(rf_we), .rf_dev_o(rf_dev),
    .rf_reg_o(rf_reg), .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata)
  );

  // register-file stub: unwritten locations hold a computed pattern
  logic [15:0]   mem [1024];
  logic [1023:0] wr_flag = '0;

  function automatic logic [15:0] pat(input logic [4:0] d, input logic [4:0] r);
    return 16'hA000 | {6'd0, d, r};
  endfunction

  assign rf_rdata = wr_flag[{rf_dev, rf_reg}] ? mem[{rf_dev, rf_reg}] : pat(rf_dev, rf_reg);

  always @(posedge clk) begin
    if (rf_req) begin
      rf_cnt <= rf_cnt + 1;
      if (rf_we) begin
        mem[{rf_dev, rf_reg}]     <= rf_wdata;
        wr_flag[{rf_dev, rf_reg}] <= 1'b1;
      end
    end
  end

  function automatic logic [15:0] mk_cmd(input logic busy_b, input logic c22,
                                         input logic [1:0] op, input logic [4:0] d,
                                         input logic [4:0] r);
    return {busy_b, 2'b00, c22, op, d, r};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the capturing edge
  task automatic xfer(input logic we, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] wd, output logic ack, output logic [15:0] rd);
    bus_req = 1'b1; bus_we = we; bus_phy = phy; bus_reg = rg; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    ack = bus_ack; rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic ind_wait(input string req);
    logic a; logic [15:0] r;
    bit idle = 1'b0;
    for (int i = 0; i < 64; i++) begin
      xfer(1'b0, strap, 5'd0, 16'd0, a, r);
      if (!r[15]) begin idle = 1'b1; break; end
    end
    chk(req, "busy clears", {31'd0, idle}, 32'd1);
  endtask

  task automatic ind_write(input logic [4:0] d, input logic [4:0] r, input logic [15:0] v);
    logic a; logic [15:0] x;
    xfer(1'b1, strap, 5'd1, v, a, x);
    xfer(1'b1, strap, 5'd0, mk_cmd(1'b1, 1'b1, 2'd1, d, r), a, x);
    ind_wait("R5");
  endtask

  task automatic ind_read(input logic [4:0] d, input logic [4:0] r, output logic [15:0] v);
    logic a;
    xfer(1'b1, strap, 5'd0, mk_cmd(1'b1, 1'b1, 2'd2, d, r), a, v);
    ind_wait("R6");
    xfer(1'b0, strap, 5'd1, 16'd0, a, v);
  endtask

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; bus_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "ack in reset", {31'd0, bus_ack}, 32'd0);
    chk("R9", "rf_req in reset", {31'd0, rf_req}, 32'd0);
    chk("R9", "rdata in reset", {16'd0, bus_rdata}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // {op[3:0], dev[4:0], reg[4:0], 2'b0, data[15:0]}; op 1 = write, 2 = read-and-compare
  localparam logic [31:0] VEC [8] = '{
    {4'd1, 5'd3,  5'd4,  2'b0, 16'hBEEF},
    {4'd2, 5'd3,  5'd4,  2'b0, 16'hBEEF},
    {4'd1, 5'd31, 5'd31, 2'b0, 16'h0001},
    {4'd2, 5'd31, 5'd31, 2'b0, 16'h0001},
    {4'd2, 5'd0,  5'd0,  2'b0, 16'hA000},
    {4'd2, 5'd10, 5'd2,  2'b0, 16'hA142},
    {4'd1, 5'd1,  5'd0,  2'b0, 16'hFFFF},
    {4'd2, 5'd1,  5'd0,  2'b0, 16'hFFFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic a; logic [15:0] r, v;
    int c0, nb;

    do_reset(5'h12);
    // R9 reset values of the indirection registers
    xfer(1'b0, strap, 5'd0, 16'd0, a, r);
    chk("R9", "cmd after reset", {16'd0, r}, 32'd0);
    xfer(1'b0, strap, 5'd1, 16'd0, a, r);
    chk("R9", "data after reset", {16'd0, r}, 32'd0);
    chk("R10", "ack on read", {31'd0, a}, 32'd1);
    @(negedge clk);
    chk("R10", "ack idle cycle", {31'd0, bus_ack}, 32'd0);

    // vector table: R5 writes, R6 reads
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][31:28] == 4'd1) ind_write(VEC[i][27:23], VEC[i][22:18], VEC[i][15:0]);
      else begin
        ind_read(VEC[i][27:23], VEC[i][22:18], v);
        chk("R6", "table read", {16'd0, v}, {16'd0, VEC[i][15:0]});
      end
    end

    // R3 busy length counted by back-to-back polls
    xfer(1'b1, strap, 5'd0, mk_cmd(1'b1, 1'b1, 2'd2, 5'd0, 5'd0), a, r);
    nb = 0;
    for (int i = 0; i < 32; i++) begin
      xfer(1'b0, strap, 5'd0, 16'd0, a, r);
      if (r[15]) nb++; else break;
    end
    chk("R3", "busy poll count", nb, LAT);
    chk("R2", "cmd readback after done", {16'd0, r},
        {16'd0, mk_cmd(1'b0, 1'b1, 2'd2, 5'd0, 5'd0)});

    // R2 command without busy bit is stored, starts nothing
    c0 = rf_cnt;
    xfer(1'b1, strap, 5'd0, 16'h1234, a, r);
    xfer(1'b0, strap, 5'd0, 16'd0, a, r);
    chk("R2", "cmd stored no busy", {16'd0, r}, 32'h1234);
    repeat (LAT + 2) @(negedge clk);
    chk("R2", "no access", rf_cnt, c0);

    // R4 second command during busy is ignored
    xfer(1'b1, strap, 5'd1, 16'hDEAD, a, r);
    c0 = rf_cnt;
    xfer(1'b1, strap, 5'd0, mk_cmd(1'b1, 1'b1, 2'd2, 5'd2, 5'd5), a, r);
    xfer(1'b1, strap, 5'd0, mk_cmd(1'b1, 1'b1, 2'd1, 5'd2, 5'd6), a, r);
    ind_wait("R4");
    chk("R4", "single access", rf_cnt, c0 + 1);
    xfer(1'b0, strap, 5'd1, 16'd0, a, r);
    chk("R4", "first cmd result", {16'd0, r}, {16'd0, pat(5'd2, 5'd5)});
    xfer(1'b0, strap, 5'd0, 16'd0, a, r);
    chk("R4", "cmd kept", {16'd0, r}, {16'd0, mk_cmd(1'b0, 1'b1, 2'd2, 5'd2, 5'd5)});
    ind_read(5'd2, 5'd6, v);
    chk("R4", "target untouched", {16'd0, v}, {16'd0, pat(5'd2, 5'd6)});

    // R7 unrecognised commands
    xfer(1'b1, strap, 5'd1, 16'h1357, a, r);
    c0 = rf_cnt;
    xfer(1'b1, strap, 5'd0, mk_cmd(1'b1, 1'b0, 2'd1, 5'd3, 5'd4), a, r);
    ind_wait("R7");
    xfer(1'b1, strap, 5'd0, mk_cmd(1'b1, 1'b1, 2'd3, 5'd3, 5'd4), a, r);
    ind_wait("R7");
    chk("R7", "no rf access", rf_cnt, c0);
    xfer(1'b0, strap, 5'd1, 16'd0, a, r);
    chk("R7", "data kept", {16'd0, r}, 32'h1357);
    ind_read(5'd3, 5'd4, v);
    chk("R7", "internal kept", {16'd0, v}, 32'hBEEF);

    // R1 foreign address
    xfer(1'b1, strap, 5'd1, 16'h4321, a, r);
    c0 = rf_cnt;
    xfer(1'b1, 5'd3, 5'd1, 16'h5555, a, r);
    chk("R1", "foreign write ack", {31'd0, a}, 32'd0);
    xfer(1'b1, 5'd3, 5'd0, mk_cmd(1'b1, 1'b1, 2'd1, 5'd3, 5'd4), a, r);
    xfer(1'b0, 5'd0, 5'd1, 16'd0, a, r);
    chk("R1", "foreign read ack", {31'd0, a}, 32'd0);
    xfer(1'b0, strap, 5'd0, 16'd0, a, r);
    chk("R1", "no busy from foreign", {31'd0, r[15]}, 32'd0);
    xfer(1'b0, strap, 5'd1, 16'd0, a, r);
    chk("R1", "data kept", {16'd0, r}, 32'h4321);
    chk("R1", "no rf access", rf_cnt, c0);

    // R11 other offsets
    xfer(1'b1, strap, 5'd5, 16'h7777, a, r);
    xfer(1'b0, strap, 5'd5, 16'd0, a, r);
    chk("R11", "other offset ack", {31'd0, a}, 32'd1);
    chk("R11", "other offset data", {16'd0, r}, 32'd0);
    xfer(1'b0, strap, 5'd1, 16'd0, a, r);
    chk("R11", "data kept", {16'd0, r}, 32'h4321);

    // R8 direct mode
    do_reset(5'd0);
    xfer(1'b1, 5'd9, 5'd7, 16'h7777, a, r);
    chk("R8", "direct write ack", {31'd0, a}, 32'd1);
    chk("R10", "write rdata zero", {16'd0, r}, 32'd0);
    xfer(1'b0, 5'd9, 5'd7, 16'd0, a, r);
    chk("R8", "direct readback", {16'd0, r}, 32'h7777);
    xfer(1'b0, 5'd0, 5'd1, 16'd0, a, r);
    chk("R8", "offset 1 is internal", {16'd0, r}, {16'd0, pat(5'd0, 5'd1)});
    xfer(1'b0, 5'd31, 5'd31, 16'd0, a, r);
    chk("R8", "any address acked", {31'd0, a}, 32'd1);
    chk("R8", "dev 31 reg 31", {16'd0, r}, 32'h0001);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule